// File: doc/BRIEF.md
# Non-Preemptive Thread Context Scheduler

This block decides which of eight hardware thread contexts on a packet-processing core owns the execution pipeline. The running context keeps the core until it gives it up. It gives it up through a yield strobe, which carries a mask of completion signals that the context will wait on. A memory request is issued as a yield with a non-zero mask. Each context uses a private register bank selected by its ID. A switch therefore moves no register state, and the next context executes in the cycle right after the yield.

Memory and coprocessor completions arrive as strobes tagged with a context ID and a signal index. A sleeping context becomes eligible again only when every signal in its wait mask has arrived. The next owner is chosen in round-robin order among eligible contexts. The search starts at the context after the one that last ran. Software brings contexts into service with per-context enable pulses. A completion that no context is waiting on is reported on an error output and otherwise has no effect.

Top module: `ctx_sched`

## Requirements
- R1: On reset, context 0 is ready and contexts 1 to 7 are inactive, with active_valid_o and proto_err_o low. In the first cycle after reset is released, context 0 becomes executing.
- R2: `ctx_state_o` bits [2c+1:2c] give the state of context c, encoded as 0 inactive, 1 ready, 2 executing, 3 sleeping. At most one context is executing. `active_valid_o` is high exactly when one is executing, and `active_ctx_o` then holds its ID.
- R3: While a context executes and `yield_i` is low, it keeps the core: same `active_ctx_o`, `active_valid_o` stays high.
- R4: A yield from the executing context takes effect at the next clock edge. The context goes to ready if its effective wait mask is zero and to sleeping otherwise. The next chosen context is executing in that same next cycle, with no idle cycle in between. A yield while `active_valid_o` is low is ignored.
- R5: When a new owner is chosen, the search runs over the contexts that are ready after this cycle's events, in round-robin order starting at `active_ctx_o`+1 (mod 8). This means a context that yields with a zero mask is picked again only if no other context is ready.
- R6: A sleeping context stays sleeping until every bit of its wait mask has been cleared by a matching completion (`done_sig_i` is the bit index in the mask). It becomes ready at the edge that clears the last bit.
- R7: A completion for the executing context that arrives in the same cycle as its yield, with a signal index set in `yield_wait_i`, is counted. That bit is removed from the stored wait mask.
- R8: A completion that targets a context not waiting on that signal raises `proto_err_o` in the next cycle and changes no context state.
- R9: When no context is ready, `active_valid_o` is low. A context that becomes ready while the core is idle, through an enable or a final completion, is executing in the following cycle.
- R10: A pulse on `ctx_enable_i[c]` moves an inactive context c to ready. It has no effect on a context in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctx_enable_i | input | 8 | Per-context enable pulses |
| yield_i | input | 1 | Executing context gives up the core |
| yield_wait_i | input | 4 | Completion signals the yielding context waits on |
| done_valid_i | input | 1 | Completion strobe |
| done_ctx_i | input | 3 | Context that the completion targets |
| done_sig_i | input | 2 | Index of the completion signal |
| active_ctx_o | output | 3 | Executing context, or the last one that ran while idle |
| active_valid_o | output | 1 | A context is executing |
| ctx_state_o | output | 16 | Packed 2-bit state per context |
| proto_err_o | output | 1 | Previous cycle carried a stray completion |

## Verification
Some situations are hard to produce from the ports. One is a completion that lands in the same cycle as the yield waiting on it. Another is the final completion that wakes a context while every other context sleeps, which must end an idle stretch at once. Both need the stimulus to know which signals each context still has pending. The random generator therefore keeps a reference model of the wait masks. It aims most completions at bits that are actually outstanding, and it sometimes targets the executing context in its own yield cycle. Directed sequences first put every context to sleep and then wake a single one.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;

    localparam int CS_NCTX = 8;
    localparam int CS_NSIG = 4;

    typedef enum logic [1:0] {
        CTX_OFF = 2'd0,
        CTX_RDY = 2'd1,
        CTX_RUN = 2'd2,
        CTX_SLP = 2'd3
    } ctx_state_t;

    function automatic logic [CS_NSIG-1:0] sig_onehot(input logic [$clog2(CS_NSIG)-1:0] idx);
        return CS_NSIG'(1) << idx;
    endfunction

endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
    import ctx_sched_pkg::*;
#(
    parameter int NSIG      = CS_NSIG,
    parameter bit RST_READY = 1'b0,
    localparam int SGW      = $clog2(NSIG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic            yield_i,
    input  logic [NSIG-1:0] wait_i,
    input  logic            done_i,
    input  logic [SGW-1:0]  done_sig_i,
    input  logic            grant_i,
    output ctx_state_t      state_o,
    output logic            cand_o,
    output logic            err_o
);
    ctx_state_t      st_q, st_pre, st_d;
    logic [NSIG-1:0] pend_q, pend_d, eff_mask, sig_bit;
    logic            hit_pend, hit_yld;

    always_comb begin
        sig_bit  = NSIG'(1) << done_sig_i;
        hit_pend = done_i && (st_q == CTX_SLP) && pend_q[done_sig_i];
        hit_yld  = done_i && yield_i && wait_i[done_sig_i];
        eff_mask = wait_i & ~(hit_yld ? sig_bit : '0);
        st_pre   = st_q;
        pend_d   = pend_q;
        if (yield_i) begin
            pend_d = eff_mask;
            st_pre = (eff_mask == '0) ? CTX_RDY : CTX_SLP;
        end else if (hit_pend) begin
            pend_d = pend_q & ~sig_bit;
            if (pend_d == '0) st_pre = CTX_RDY;
        end else if ((st_q == CTX_OFF) && en_i) begin
            st_pre = CTX_RDY;
        end
        err_o  = done_i && !hit_pend && !hit_yld;
        cand_o = (st_pre == CTX_RDY);
        st_d   = grant_i ? CTX_RUN : st_pre;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= RST_READY ? CTX_RDY : CTX_OFF;
            pend_q <= '0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    assign state_o = st_q;
endmodule

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  gnt_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = last_i;
        for (int i = 1; i <= N; i++) begin
            int k;
            k = (int'(last_i) + i) % N;
            if (!any_o && req_i[k]) begin
                any_o = 1'b1;
                idx_o = IW'(k);
            end
        end
        gnt_o = any_o ? (N'(1) << idx_o) : '0;
    end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
    import ctx_sched_pkg::*;
#(
    parameter int NCTX = CS_NCTX,
    parameter int NSIG = CS_NSIG,
    localparam int IDW = $clog2(NCTX),
    localparam int SGW = $clog2(NSIG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCTX-1:0]   ctx_enable_i,
    input  logic              yield_i,
    input  logic [NSIG-1:0]   yield_wait_i,
    input  logic              done_valid_i,
    input  logic [IDW-1:0]    done_ctx_i,
    input  logic [SGW-1:0]    done_sig_i,
    output logic [IDW-1:0]    active_ctx_o,
    output logic              active_valid_o,
    output logic [2*NCTX-1:0] ctx_state_o,
    output logic              proto_err_o
);
    logic [IDW-1:0]  act_id_q;
    logic            act_vld_q;
    logic            err_q;
    logic [NCTX-1:0] cand, gnt, slot_err;
    logic            any_cand, need_pick, yield_ok;
    logic [IDW-1:0]  pick_idx;

    assign yield_ok  = yield_i && act_vld_q;
    assign need_pick = !act_vld_q || yield_ok;

    for (genvar c = 0; c < NCTX; c++) begin : g_slot
        ctx_state_t st_c;
        ctx_slot #(
            .NSIG      (NSIG),
            .RST_READY (c == 0)
        ) slot_i (
            .clk        (clk),
            .rst        (rst),
            .en_i       (ctx_enable_i[c]),
            .yield_i    (yield_ok && (act_id_q == IDW'(c))),
            .wait_i     (yield_wait_i),
            .done_i     (done_valid_i && (done_ctx_i == IDW'(c))),
            .done_sig_i (done_sig_i),
            .grant_i    (need_pick && gnt[c]),
            .state_o    (st_c),
            .cand_o     (cand[c]),
            .err_o      (slot_err[c])
        );
        assign ctx_state_o[2*c +: 2] = st_c;
    end

    ctx_rr_pick #(.N(NCTX)) pick_i (
        .req_i  (cand),
        .last_i (act_id_q),
        .any_o  (any_cand),
        .idx_o  (pick_idx),
        .gnt_o  (gnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_id_q  <= IDW'(NCTX - 1);
            act_vld_q <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            err_q <= |slot_err;
            if (need_pick) begin
                act_vld_q <= any_cand;
                if (any_cand) act_id_q <= pick_idx;
            end
        end
    end

    assign active_ctx_o   = act_id_q;
    assign active_valid_o = act_vld_q;
    assign proto_err_o    = err_q;
endmodule

// File: rtl/ctx_sched_chk.sv
module ctx_sched_chk #(
    parameter int NCTX = 8,
    parameter int NSIG = 4,
    localparam int IDW = $clog2(NCTX),
    localparam int SGW = $clog2(NSIG)
) (
    input logic              clk,
    input logic              rst,
    input logic              yield_i,
    input logic [NSIG-1:0]   yield_wait_i,
    input logic              done_valid_i,
    input logic [IDW-1:0]    done_ctx_i,
    input logic [SGW-1:0]    done_sig_i,
    input logic [IDW-1:0]    active_ctx_o,
    input logic              active_valid_o,
    input logic [2*NCTX-1:0] ctx_state_o,
    input logic              proto_err_o
);
    logic [NCTX-1:0] run_vec, rdy_vec;
    logic [IDW-1:0]  prev_ctx;

    always_comb begin
        for (int c = 0; c < NCTX; c++) begin
            run_vec[c] = (ctx_state_o[2*c +: 2] == 2'd2);
            rdy_vec[c] = (ctx_state_o[2*c +: 2] == 2'd1);
        end
    end

    always_ff @(posedge clk) prev_ctx <= active_ctx_o;

    a_r2_single_run: assert property (@(posedge clk) disable iff (rst)
        $countones(run_vec) == (active_valid_o ? 1 : 0));

    a_r2_run_matches_id: assert property (@(posedge clk) disable iff (rst)
        active_valid_o |-> run_vec[active_ctx_o]);

    a_r3_no_preempt: assert property (@(posedge clk) disable iff (rst)
        (active_valid_o && !yield_i) |=> (active_valid_o && active_ctx_o == prev_ctx));

    a_r4_sleep_on_wait: assert property (@(posedge clk) disable iff (rst)
        (active_valid_o && yield_i && (yield_wait_i != '0) &&
         !(done_valid_i && done_ctx_i == active_ctx_o))
        |=> (ctx_state_o[2*prev_ctx +: 2] == 2'd3));

    a_r8_stray_flag: assert property (@(posedge clk) disable iff (rst)
        (done_valid_i && ctx_state_o[2*done_ctx_i +: 2] != 2'd3 &&
         !(yield_i && active_valid_o && active_ctx_o == done_ctx_i))
        |=> proto_err_o);

    a_r9_idle_wake: assert property (@(posedge clk) disable iff (rst)
        (!active_valid_o && (rdy_vec != '0)) |=> active_valid_o);

    logic unused_sig;
    assign unused_sig = ^done_sig_i;
endmodule

bind ctx_sched ctx_sched_chk #(.NCTX(NCTX), .NSIG(NSIG)) chk_i (
    .clk            (clk),
    .rst            (rst),
    .yield_i        (yield_i),
    .yield_wait_i   (yield_wait_i),
    .done_valid_i   (done_valid_i),
    .done_ctx_i     (done_ctx_i),
    .done_sig_i     (done_sig_i),
    .active_ctx_o   (active_ctx_o),
    .active_valid_o (active_valid_o),
    .ctx_state_o    (ctx_state_o),
    .proto_err_o    (proto_err_o)
);

// File: tb/ctx_sched_tb_top.sv
module ctx_sched_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  en = '0;
    logic        yld = 1'b0;
    logic [3:0]  wmask = '0;
    logic        dv = 1'b0;
    logic [2:0]  dctx = '0;
    logic [1:0]  dsig = '0;
    logic [2:0]  act_ctx;
    logic        act_vld;
    logic [15:0] st_vec;
    logic        perr;

    int checks = 0;
    int fails  = 0;

    int         m_st[8];
    logic [3:0] m_pend[8];
    bit         m_valid;
    int         m_ctx;
    bit         m_err;

    always #2 clk = ~clk;

    ctx_sched dut_i (
        .clk            (clk),
        .rst            (rst),
        .ctx_enable_i   (en),
        .yield_i        (yld),
        .yield_wait_i   (wmask),
        .done_valid_i   (dv),
        .done_ctx_i     (dctx),
        .done_sig_i     (dsig),
        .active_ctx_o   (act_ctx),
        .active_valid_o (act_vld),
        .ctx_state_o    (st_vec),
        .proto_err_o    (perr)
    );

    function automatic logic [15:0] exp_vec();
        logic [15:0] v;
        for (int c = 0; c < 8; c++) v[2*c +: 2] = 2'(m_st[c]);
        return v;
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 8; c++) begin
            m_st[c]   = (c == 0) ? 1 : 0;
            m_pend[c] = '0;
        end
        m_valid = 0;
        m_ctx   = 7;
        m_err   = 0;
    endtask

    task automatic model_step();
        bit cand[8];
        bit nerr = 0;
        bit need;
        bit found = 0;
        for (int c = 0; c < 8; c++) begin
            bit y, d, hp, hy;
            logic [3:0] eff;
            y  = m_valid && yld && (m_ctx == c);
            d  = dv && (int'(dctx) == c);
            hp = d && (m_st[c] == 3) && m_pend[c][dsig];
            hy = d && y && wmask[dsig];
            if (d && !hp && !hy) nerr = 1;
            if (y) begin
                eff = wmask & ~(hy ? (4'b1 << dsig) : 4'b0);
                m_pend[c] = eff;
                m_st[c] = (eff == 0) ? 1 : 3;
            end else if (hp) begin
                m_pend[c] = m_pend[c] & ~(4'b1 << dsig);
                if (m_pend[c] == 0) m_st[c] = 1;
            end else if (m_st[c] == 0 && en[c]) begin
                m_st[c] = 1;
            end
            cand[c] = (m_st[c] == 1);
        end
        need = !m_valid || yld;
        if (need) begin
            for (int i = 1; i <= 8; i++) begin
                int k;
                k = (m_ctx + i) % 8;
                if (!found && cand[k]) begin
                    found = 1;
                    m_st[k] = 2;
                    m_ctx = k;
                end
            end
            m_valid = found;
        end
        m_err = nerr;
    endtask

    task automatic check_all(string tag);
        checks++;
        if (st_vec !== exp_vec()) begin
            fails++;
            $display("FAIL %s state vector actual=%h expected=%h", tag, st_vec, exp_vec());
        end
        checks++;
        if (act_vld !== m_valid) begin
            fails++;
            $display("FAIL %s active_valid actual=%0d expected=%0d", tag, act_vld, m_valid);
        end
        if (m_valid) begin
            checks++;
            if (int'(act_ctx) != m_ctx) begin
                fails++;
                $display("FAIL %s active_ctx actual=%0d expected=%0d", tag, act_ctx, m_ctx);
            end
        end
        checks++;
        if (perr !== m_err) begin
            fails++;
            $display("FAIL %s proto_err actual=%0d expected=%0d", tag, perr, m_err);
        end
    endtask

    task automatic cyc(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
        en = '0; yld = 0; wmask = '0; dv = 0;
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL R3 watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check_all("R1");
        cyc("R1");

        // R3: context 0 holds the core without a yield
        cyc("R3"); cyc("R3");

        // R10: enable the rest; running context 0 is unaffected
        en = 8'hFF; cyc("R10");
        en = 8'hFF; cyc("R10");

        // R5: zero-mask yield hands over to context 1
        yld = 1; wmask = 4'b0000; cyc("R5");
        // R4: context 1 sleeps on two signals, context 2 runs
        yld = 1; wmask = 4'b0011; cyc("R4");
        // R6: first completion only
        dv = 1; dctx = 3'd1; dsig = 2'd0; cyc("R6");
        dv = 1; dctx = 3'd1; dsig = 2'd1; cyc("R6");
        // R8: stray completion to a ready context
        dv = 1; dctx = 3'd5; dsig = 2'd2; cyc("R8");
        cyc("R8");
        // R7: completion in the yield cycle
        yld = 1; wmask = 4'b0001; dv = 1; dctx = 3'(m_ctx); dsig = 2'd0; cyc("R7");
        // R4: yield ignored while idle is covered below; put all to sleep
        for (int i = 0; i < 10; i++) begin
            if (m_valid) begin
                yld = 1; wmask = 4'b1000;
            end
            cyc("R9");
        end
        yld = 1; wmask = 4'b0001; cyc("R4");
        cyc("R9");
        // R9: one final completion wakes context 4 straight into execution
        dv = 1; dctx = 3'd4; dsig = 2'd3; cyc("R9");
        cyc("R9");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            yld   = ($urandom % 100) < 30;
            wmask = (($urandom % 2) == 0) ? 4'($urandom % 16) : 4'b0;
            dv    = ($urandom % 100) < 55;
            dctx  = 3'($urandom % 8);
            dsig  = 2'($urandom % 4);
            if (m_st[dctx] == 3 && ($urandom % 10) < 8) begin
                for (int k = 0; k < 4; k++)
                    if (m_pend[dctx][k]) dsig = 2'(k);
            end
            if (m_valid && yld && ($urandom % 8) == 0) begin
                dv = 1; dctx = 3'(m_ctx); wmask = wmask | 4'b0100; dsig = 2'd2;
            end
            en = (($urandom % 100) < 3) ? 8'($urandom) : 8'h00;
            cyc("R2 R3 R4 R5 R6 R7 R8");
        end
        finish_run();
    end
endmodule